// File: doc/BRIEF.md
# DQS Data-Eye Window Search Engine

This block calibrates the strobe timing of a DDR memory interface. A single-cycle `go` pulse starts a two-level sweep. The outer level is a coarse write-strobe shift. The inner level is a fine strobe delay that is copied into every byte-lane delay field. For each pair of settings the engine does four things in turn:

- drops the memory controller's start line and writes the settings;
- raises start again;
- waits for delay-line lock, then for DRAM initialisation complete, then for a settle interval;
- asks an external pattern checker for a pass or fail verdict.

The engine tracks runs of consecutive passing fine delays inside one coarse value and keeps the best run. When the sweep ends, it programs the midpoint of the best run together with the coarse shift that produced it. It then runs one last start/lock/init sequence and reports done.

The delay line, the memory controller and the pattern checker are outside the block. Only their handshake signals are seen here. If lock or init-complete does not arrive within a cycle budget set on a port, the engine stops with an error flag and leaves the failing settings on its outputs. If no trial passes, it finishes with a no-window flag and does not program a midpoint.

Top module: `dqs_eye_search`

## Requirements
- R1: After reset, `ctl_start`, `test_req`, `cal_done`, `cal_err` and `no_window` are low, and `best_count` is zero.
- R2: A sweep visits coarse shifts 64 to 95 in the outer loop and fine delays 1 to 63 in the inner loop. That gives 2016 trials, each with exactly one rising edge of `ctl_start` and one rising edge of `test_req`. A successful window search adds one more rising edge of `ctl_start` for the final programming.
- R3: `out_shift` equals `wr_shift` plus 32. The fine delay drives all nine lane fields identically; lane i occupies `lane_delay[6*i+5:6*i]`.
- R4: Within a trial, the settings change only while `ctl_start` is low, and they stay unchanged on the cycle `ctl_start` rises. `test_req` rises only while `ctl_start`, `dll_lock` and `init_done` are all high. `test_req` drops on the cycle after `test_done` is seen.
- R5: A failing trial ends the current run, and a new coarse shift also starts a fresh run. Passing delays therefore never join across a failure or across two coarse shifts.
- R6: A run whose length is greater than or equal to the best length so far replaces the best. Its length, coarse shift, first delay and last delay are stored, so on a tie the later run wins.
- R7: At the end of the sweep, the fine delay is programmed as floor((best start + best end) / 2) and the coarse shift as the best coarse shift. One more start/lock/init/settle sequence follows. Then `cal_done` rises and `ctl_start` stays high.
- R8: If `dll_lock` stays low for more than `wait_limit` cycles, the engine stops with `cal_err` high and `cal_done` low. `wr_shift` and `lane_delay` keep the failing trial's values.
- R9: If `init_done` stays low for more than `wait_limit` cycles after lock, the engine stops in the same way as in R8.
- R10: If no trial passes, `cal_done` and `no_window` rise with `best_count` equal to zero, and `ctl_start` is low.
- R11: A `go` pulse while a sweep is running has no effect on the sweep or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Single-cycle calibration start |
| wait_limit | input | 16 | Lock and init timeout in cycles |
| dll_lock | input | 1 | Delay line locked |
| init_done | input | 1 | DRAM initialisation complete |
| test_done | input | 1 | Pattern test verdict valid |
| test_pass | input | 1 | Pattern test passed |
| ctl_start | output | 1 | Memory controller start |
| test_req | output | 1 | Pattern test request, held until `test_done` |
| wr_shift | output | 7 | Coarse write-strobe shift |
| out_shift | output | 8 | Output strobe shift (coarse + 32) |
| lane_delay | output | 54 | Nine 6-bit fine delay fields |
| cal_done | output | 1 | Calibration finished |
| cal_err | output | 1 | Lock or init timeout |
| no_window | output | 1 | No passing trial found |
| best_start | output | 6 | First delay of best window |
| best_end | output | 6 | Last delay of best window |
| best_count | output | 7 | Length of best window |
| best_shift | output | 7 | Coarse shift of best window |

## Verification
The settings registers load one cycle before `ctl_start` rises. `test_req` rises on the clock edge after the settle counter expires and falls on the edge after `test_done`. The bench's models therefore sample `ctl_start`, `test_req` and the settings on the falling edge and compare each against its value from the previous falling edge. In particular, they check that no setting moves on the cycle `ctl_start` rises. Final results are due on the edge that raises `cal_done` or `cal_err`. Those flags stay high, so each scenario polls for them on falling edges and then reads every result in the same cycle.

// File: rtl/dqs_eye_pkg.sv
package dqs_eye_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_APPLY,
    ST_ARM,
    ST_LOCK,
    ST_INIT,
    ST_SETTLE,
    ST_TEST,
    ST_EVAL,
    ST_DONE,
    ST_FAIL
  } cal_state_e;

endpackage

// File: rtl/dqs_wait_timer.sv
module dqs_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)                 cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= limit);

  // R8: the wait counter only moves up between restarts
  p_timer_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/dqs_window_track.sv
module dqs_window_track #(
  parameter int FW   = 6,
  parameter int CW   = 7,
  parameter int CNTW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            eval,
  input  logic            pass,
  input  logic            run_clr,
  input  logic [FW-1:0]   fine,
  input  logic [CW-1:0]   coarse,
  output logic [CNTW-1:0] best_cnt,
  output logic [FW-1:0]   best_lo,
  output logic [FW-1:0]   best_hi,
  output logic [CW-1:0]   best_cs
);

  logic [CNTW-1:0] run_q, run_d, best_q, best_d;
  logic [FW-1:0]   rlo_q, rlo_d, blo_q, blo_d, bhi_q, bhi_d;
  logic [CW-1:0]   bcs_q, bcs_d;
  logic [CNTW-1:0] run_inc;
  logic [FW-1:0]   lo_pick;

  assign run_inc = run_q + 1'b1;
  assign lo_pick = (run_q == '0) ? fine : rlo_q;

  always_comb begin
    run_d  = run_q;
    rlo_d  = rlo_q;
    best_d = best_q;
    blo_d  = blo_q;
    bhi_d  = bhi_q;
    bcs_d  = bcs_q;
    if (clr) begin
      run_d  = '0;
      rlo_d  = '0;
      best_d = '0;
      blo_d  = '0;
      bhi_d  = '0;
      bcs_d  = '0;
    end else if (eval) begin
      if (pass) begin
        run_d = run_inc;
        rlo_d = lo_pick;
        if (run_inc >= best_q) begin
          best_d = run_inc;
          blo_d  = lo_pick;
          bhi_d  = fine;
          bcs_d  = coarse;
        end
      end else begin
        run_d = '0;
      end
    end else if (run_clr) begin
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      rlo_q  <= '0;
      best_q <= '0;
      blo_q  <= '0;
      bhi_q  <= '0;
      bcs_q  <= '0;
    end else begin
      run_q  <= run_d;
      rlo_q  <= rlo_d;
      best_q <= best_d;
      blo_q  <= blo_d;
      bhi_q  <= bhi_d;
      bcs_q  <= bcs_d;
    end
  end

  assign best_cnt = best_q;
  assign best_lo  = blo_q;
  assign best_hi  = bhi_q;
  assign best_cs  = bcs_q;

  // R6: the best length never shrinks within one calibration
  p_best_nondecreasing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> best_q >= $past(best_q));

  // R5: a failing verdict leaves no open run
  p_fail_ends_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !pass && !clr) |=> run_q == '0);

  // R6: a stored window never ends before it starts
  p_window_ordered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    best_q != '0 |-> bhi_q >= blo_q);

endmodule

// File: rtl/dqs_lane_fanout.sv
module dqs_lane_fanout #(
  parameter int LANES = 9,
  parameter int FW    = 6
) (
  input  logic [FW-1:0]       fine,
  output logic [LANES*FW-1:0] lanes
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes[i*FW +: FW] = fine;
  end

endmodule

// File: rtl/dqs_eye_search.sv
module dqs_eye_search
  import dqs_eye_pkg::*;
#(
  parameter int CW         = 7,
  parameter int FW         = 6,
  parameter int LANES      = 9,
  parameter int TW         = 16,
  parameter int COARSE_LO  = 64,
  parameter int COARSE_HI  = 95,
  parameter int FINE_LO    = 1,
  parameter int FINE_HI    = 63,
  parameter int SHIFT_OFS  = 32,
  parameter int SETTLE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [TW-1:0]        wait_limit,
  input  logic                 dll_lock,
  input  logic                 init_done,
  input  logic                 test_done,
  input  logic                 test_pass,
  output logic                 ctl_start,
  output logic                 test_req,
  output logic [CW-1:0]        wr_shift,
  output logic [CW:0]          out_shift,
  output logic [LANES*FW-1:0]  lane_delay,
  output logic                 cal_done,
  output logic                 cal_err,
  output logic                 no_window,
  output logic [FW-1:0]        best_start,
  output logic [FW-1:0]        best_end,
  output logic [FW:0]          best_count,
  output logic [CW-1:0]        best_shift
);

  localparam int CNTW = FW + 1;
  localparam int OSW  = CW + 1;
  localparam logic [CW-1:0]  C_LO   = CW'(COARSE_LO);
  localparam logic [CW-1:0]  C_HI   = CW'(COARSE_HI);
  localparam logic [FW-1:0]  F_LO   = FW'(FINE_LO);
  localparam logic [FW-1:0]  F_HI   = FW'(FINE_HI);
  localparam logic [OSW-1:0] OFS    = OSW'(SHIFT_OFS);
  localparam logic [TW-1:0]  SETTLE = TW'(SETTLE_CYC);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  cal_state_e st_q, st_d;
  logic [CW-1:0]  cidx_q, cidx_d;
  logic [FW-1:0]  fidx_q, fidx_d;
  logic           fin_q, fin_d;
  logic [CW-1:0]  wsh_q, wsh_d;
  logic [OSW-1:0] osh_q, osh_d;
  logic [FW-1:0]  fdel_q, fdel_d;
  logic           start_q, start_d;
  logic           req_q, req_d;
  logic           done_q, done_d;
  logic           err_q, err_d;
  logic           nowin_q, nowin_d;

  logic           trk_clr, trk_eval, run_clr;
  logic [CNTW-1:0] bcnt;
  logic [FW-1:0]  blo, bhi;
  logic [CW-1:0]  bcs;
  logic [FW:0]    mid_sum;
  logic [FW-1:0]  mid;

  logic           tmr_clr, tmr_exp;
  logic [TW-1:0]  tmr_lim;

  assign mid_sum = {1'b0, blo} + {1'b0, bhi};
  assign mid     = mid_sum[FW:1];

  assign tmr_clr = (st_d != st_q);
  assign tmr_lim = (st_q == ST_SETTLE) ? SETTLE : wait_limit;

  dqs_wait_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (tmr_clr),
    .limit   (tmr_lim),
    .expired (tmr_exp)
  );

  dqs_window_track #(.FW(FW), .CW(CW), .CNTW(CNTW)) u_track (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (trk_clr),
    .eval     (trk_eval),
    .pass     (test_pass),
    .run_clr  (run_clr),
    .fine     (fidx_q),
    .coarse   (cidx_q),
    .best_cnt (bcnt),
    .best_lo  (blo),
    .best_hi  (bhi),
    .best_cs  (bcs)
  );

  dqs_lane_fanout #(.LANES(LANES), .FW(FW)) u_fanout (
    .fine  (fdel_q),
    .lanes (lane_delay)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    cidx_d   = cidx_q;
    fidx_d   = fidx_q;
    fin_d    = fin_q;
    wsh_d    = wsh_q;
    osh_d    = osh_q;
    fdel_d   = fdel_q;
    start_d  = start_q;
    req_d    = req_q;
    done_d   = done_q;
    err_d    = err_q;
    nowin_d  = nowin_q;
    trk_clr  = 1'b0;
    trk_eval = 1'b0;
    run_clr  = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (go) begin
          cidx_d  = C_LO;
          fidx_d  = F_LO;
          fin_d   = 1'b0;
          start_d = 1'b0;
          done_d  = 1'b0;
          err_d   = 1'b0;
          nowin_d = 1'b0;
          trk_clr = 1'b1;
          st_d    = ST_APPLY;
        end
      end
      ST_APPLY: begin
        if (fin_q) begin
          wsh_d  = bcs;
          fdel_d = mid;
        end else begin
          wsh_d  = cidx_q;
          fdel_d = fidx_q;
        end
        osh_d = OSW'(wsh_d) + OFS;
        st_d  = ST_ARM;
      end
      ST_ARM: begin
        start_d = 1'b1;
        st_d    = ST_LOCK;
      end
      ST_LOCK: begin
        if (dll_lock) begin
          st_d = ST_INIT;
        end else if (tmr_exp) begin
          err_d = 1'b1;
          st_d  = ST_FAIL;
        end
      end
      ST_INIT: begin
        if (init_done) begin
          st_d = ST_SETTLE;
        end else if (tmr_exp) begin
          err_d = 1'b1;
          st_d  = ST_FAIL;
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) begin
          if (fin_q) begin
            done_d = 1'b1;
            st_d   = ST_DONE;
          end else begin
            req_d = 1'b1;
            st_d  = ST_TEST;
          end
        end
      end
      ST_TEST: begin
        if (test_done) begin
          req_d    = 1'b0;
          trk_eval = 1'b1;
          st_d     = ST_EVAL;
        end
      end
      ST_EVAL: begin
        start_d = 1'b0;
        if (fidx_q == F_HI) begin
          run_clr = 1'b1;
          fidx_d  = F_LO;
          if (cidx_q == C_HI) begin
            if (bcnt == '0) begin
              nowin_d = 1'b1;
              done_d  = 1'b1;
              st_d    = ST_DONE;
            end else begin
              fin_d = 1'b1;
              st_d  = ST_APPLY;
            end
          end else begin
            cidx_d = cidx_q + 1'b1;
            st_d   = ST_APPLY;
          end
        end else begin
          fidx_d = fidx_q + 1'b1;
          st_d   = ST_APPLY;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= ST_IDLE;
      cidx_q  <= '0;
      fidx_q  <= '0;
      fin_q   <= 1'b0;
      wsh_q   <= '0;
      osh_q   <= '0;
      fdel_q  <= '0;
      start_q <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      nowin_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cidx_q  <= cidx_d;
      fidx_q  <= fidx_d;
      fin_q   <= fin_d;
      wsh_q   <= wsh_d;
      osh_q   <= osh_d;
      fdel_q  <= fdel_d;
      start_q <= start_d;
      req_q   <= req_d;
      done_q  <= done_d;
      err_q   <= err_d;
      nowin_q <= nowin_d;
    end
  end

  assign ctl_start  = start_q;
  assign test_req   = req_q;
  assign wr_shift   = wsh_q;
  assign out_shift  = osh_q;
  assign cal_done   = done_q;
  assign cal_err    = err_q;
  assign no_window  = nowin_q;
  assign best_start = blo;
  assign best_end   = bhi;
  assign best_count = bcnt;
  assign best_shift = bcs;

  // R4: a settings write never overlaps an asserted start
  p_quiet_settings_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (fdel_q != $past(fdel_q) || wsh_q != $past(wsh_q)) |-> !start_q);

  // R4: the pattern test runs only under an asserted start
  p_req_under_start_r4: assert property (@(posedge clk) disable iff (!rst_i)
    req_q |-> start_q);

  // R4: the request is withdrawn once the verdict arrives
  p_req_release_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (req_q && test_done) |=> !req_q);

  // R3: the output strobe shift tracks the coarse shift whenever start is up
  p_shift_offset_r3: assert property (@(posedge clk) disable iff (!rst_i)
    start_q |-> osh_q == OSW'(wsh_q) + OFS);

  // R8: done and error are exclusive
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_i)
    !(done_q && err_q));

  // R10: the no-window flag only comes with an empty best window
  p_nowin_empty_r10: assert property (@(posedge clk) disable iff (!rst_i)
    nowin_q |-> (done_q && bcnt == '0));

endmodule

// File: tb/dqs_eye_search_bench.sv
module dqs_eye_search_bench;

  localparam int CLK_NS = 10;
  localparam int LANES  = 9;
  localparam int FW     = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [15:0] wait_limit = 16'd20;
  logic        dll_lock = 1'b0;
  logic        init_done = 1'b0;
  logic        test_done = 1'b0;
  logic        test_pass = 1'b0;
  logic        ctl_start, test_req, cal_done, cal_err, no_window;
  logic [6:0]  wr_shift, best_shift;
  logic [7:0]  out_shift;
  logic [53:0] lane_delay;
  logic [5:0]  best_start, best_end;
  logic [6:0]  best_count;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // models' knobs and observations
  int win_n = 0;
  int win_c [3];
  int win_lo[3];
  int win_hi[3];
  bit kill_lock = 0, kill_init = 0;
  int kill_c = 0, kill_f = 0;
  int n_start = 0, n_req = 0, n_seq_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  dqs_eye_search #(.SETTLE_CYC(2)) u_dqs_eye_search (
    .clk, .rst_n, .go, .wait_limit, .dll_lock, .init_done, .test_done,
    .test_pass, .ctl_start, .test_req, .wr_shift, .out_shift, .lane_delay,
    .cal_done, .cal_err, .no_window, .best_start, .best_end, .best_count,
    .best_shift
  );

  function automatic bit pass_fn(int c, int f);
    for (int i = 0; i < win_n; i++)
      if (c == win_c[i] && f >= win_lo[i] && f <= win_hi[i]) return 1'b1;
    return 1'b0;
  endfunction

  // controller, delay line and pattern checker models, sampled off-edge
  initial begin
    int scnt = 0, tcnt = 0;
    logic prev_start = 0, prev_req = 0;
    logic [6:0]  prev_ws = '0;
    logic [53:0] prev_ln = '0;
    bit hit;
    forever begin
      @(negedge clk);
      hit = (int'(wr_shift) == kill_c) && (int'(lane_delay[5:0]) == kill_f);
      if (!ctl_start) begin
        scnt = 0; dll_lock = 0; init_done = 0;
      end else begin
        scnt++;
        dll_lock  = (scnt >= 2) && !(kill_lock && hit);
        init_done = dll_lock && (scnt >= 4) && !(kill_init && hit);
      end
      if (ctl_start && !prev_start) begin
        n_start++;
        if (wr_shift != prev_ws || lane_delay != prev_ln) n_seq_bad++;
      end
      if (test_req && !prev_req) begin
        n_req++;
        if (!(ctl_start && dll_lock && init_done)) n_seq_bad++;
      end
      if (test_done) begin
        test_done = 0; tcnt = 0;
      end else if (test_req) begin
        tcnt++;
        if (tcnt == 2) begin
          test_done = 1;
          test_pass = pass_fn(int'(wr_shift), int'(lane_delay[5:0]));
        end
      end else begin
        tcnt = 0;
      end
      prev_start = ctl_start; prev_req = test_req;
      prev_ws = wr_shift; prev_ln = lane_delay;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_cal(bit extra_go);
    int n = 0;
    n_start = 0; n_req = 0; n_seq_bad = 0;
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
    if (extra_go) begin
      repeat (300) @(negedge clk);
      go = 1; @(negedge clk); go = 0;
    end
    while (!(cal_done || cal_err) && n < 40000) begin
      @(negedge clk); n++;
    end
    chk("R2", "run finished in budget", int'(n < 40000), 1);
  endtask

  task automatic chk_lanes(string req, int exp);
    for (int i = 0; i < LANES; i++)
      chk(req, $sformatf("lane %0d delay", i), int'(lane_delay[i*FW +: FW]), exp);
  endtask

  task automatic set_win(int idx, int c, int lo, int hi);
    win_c[idx] = c; win_lo[idx] = lo; win_hi[idx] = hi;
  endtask

  task automatic t_reset;
    chk("R1", "ctl_start", int'(ctl_start), 0);
    chk("R1", "test_req", int'(test_req), 0);
    chk("R1", "cal_done", int'(cal_done), 0);
    chk("R1", "cal_err", int'(cal_err), 0);
    chk("R1", "no_window", int'(no_window), 0);
    chk("R1", "best_count", int'(best_count), 0);
  endtask

  // two windows of different width, plus a go pulse mid-sweep (R11)
  task automatic t_main;
    kill_lock = 0; kill_init = 0;
    set_win(0, 70, 10, 20); set_win(1, 80, 30, 45); win_n = 2;
    run_cal(1'b1);
    chk("R2", "start pulses", n_start, 2017);
    chk("R2", "test requests", n_req, 2016);
    chk("R4", "sequence violations", n_seq_bad, 0);
    chk("R11", "cal_done", int'(cal_done), 1);
    chk("R11", "best_shift", int'(best_shift), 80);
    chk("R6", "best_start", int'(best_start), 30);
    chk("R6", "best_end", int'(best_end), 45);
    chk("R6", "best_count", int'(best_count), 16);
    chk("R7", "wr_shift", int'(wr_shift), 80);
    chk("R3", "out_shift", int'(out_shift), 112);
    chk_lanes("R7", 37);
    chk("R7", "ctl_start held", int'(ctl_start), 1);
    chk("R10", "no_window", int'(no_window), 0);
  endtask

  // equal widths: the later coarse shift wins
  task automatic t_tie;
    set_win(0, 66, 5, 14); set_win(1, 90, 40, 49); win_n = 2;
    run_cal(1'b0);
    chk("R6", "tie best_shift", int'(best_shift), 90);
    chk("R6", "tie best_start", int'(best_start), 40);
    chk("R6", "tie best_count", int'(best_count), 10);
    chk("R3", "tie out_shift", int'(out_shift), 122);
    chk_lanes("R7", 44);
  endtask

  // runs split by a coarse step and by a failure; odd midpoint truncates
  task automatic t_boundary;
    set_win(0, 70, 60, 63); set_win(1, 71, 1, 3); set_win(2, 72, 10, 12);
    win_n = 3;
    run_cal(1'b0);
    chk("R5", "best_shift", int'(best_shift), 70);
    chk("R5", "best_count", int'(best_count), 4);
    chk("R5", "best_end", int'(best_end), 63);
    chk_lanes("R7", 61);
  endtask

  task automatic t_split;
    set_win(0, 72, 10, 12); set_win(1, 72, 14, 16); win_n = 2;
    run_cal(1'b0);
    chk("R5", "split best_count", int'(best_count), 3);
    chk("R5", "split best_start", int'(best_start), 14);
  endtask

  task automatic t_nowin;
    win_n = 0;
    run_cal(1'b0);
    chk("R10", "cal_done", int'(cal_done), 1);
    chk("R10", "no_window", int'(no_window), 1);
    chk("R10", "best_count", int'(best_count), 0);
    chk("R10", "ctl_start", int'(ctl_start), 0);
  endtask

  task automatic t_lock_to;
    kill_c = 64; kill_f = 3; kill_lock = 1; kill_init = 0;
    run_cal(1'b0);
    chk("R8", "cal_err", int'(cal_err), 1);
    chk("R8", "cal_done", int'(cal_done), 0);
    chk("R8", "wr_shift", int'(wr_shift), 64);
    chk_lanes("R8", 3);
    chk("R8", "start pulses", n_start, 3);
    kill_lock = 0;
  endtask

  task automatic t_init_to;
    kill_c = 65; kill_f = 1; kill_init = 1; kill_lock = 0;
    run_cal(1'b0);
    chk("R9", "cal_err", int'(cal_err), 1);
    chk("R9", "cal_done", int'(cal_done), 0);
    chk("R9", "wr_shift", int'(wr_shift), 65);
    chk_lanes("R9", 1);
    chk("R9", "start pulses", n_start, 64);
    kill_init = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lock_to();
    t_init_to();
    t_main();
    t_tie();
    t_boundary();
    t_split();
    t_nowin();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 195000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule